// File: doc/BRIEF.md
# Fully-Associative Conflict Bypass Buffer

This block is a small store of whole cache lines that sits next to a set-associative cache and is searched in the same cycle as that cache. A privileged requester, such as a thread that must always make forward progress, can be refused a way in the main cache because every way of its set is pinned. When that happens the refill line is written into this buffer instead. Any later access to that line finds it here with no extra latency.

Placement is fully associative over `ENTRIES` slots, and replacement is least recently used. The search is purely combinational. The surrounding pipeline gives the block the main cache's hit flag and data, and receives a merged hit and line back. A line held here takes priority over the main cache copy. An invalidate port removes a line. The invalidate takes effect for a same-cycle lookup or fill, and the slot is freed at the next clock edge.

Top module: `bypass_buf`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), every slot is empty, so every lookup misses in the buffer. While `rst_n` is low, `fill_taken` stays 0.
- R2: A fill is accepted only when `fill_valid`, `fill_priv` and `fill_conflict` are all 1 in the same cycle. `fill_taken` reports this combinationally in that cycle. A fill that is not accepted changes no slot.
- R3: From the cycle after an accepted fill, a lookup of that line returns `lk_hit`=1, `lk_from_bb`=1 and the filled line on `lk_data`.
- R4: A lookup is answered combinationally in the cycle that `lk_valid` is high, against every slot. With `lk_valid` low, `lk_hit` and `lk_from_bb` are 0.
- R5: `lk_hit` is the OR of the buffer hit and `mc_hit`. When the buffer hits, `lk_data` is the buffer's line even if `mc_hit` is 1. When only the main cache hits, `lk_data` equals `mc_data` and `lk_from_bb` is 0.
- R6: An accepted fill of a new line writes the lowest-numbered empty slot. If no slot is empty, it writes the least recently used slot. An accepted fill and a buffer lookup hit both make their slot the most recent. When both happen in the same cycle, only the fill's slot is updated.
- R7: A fill of a line that is already held rewrites that slot in place and evicts nothing.
- R8: An invalidate clears the slot holding its line at the next edge. In the same cycle, a lookup of that line reports a buffer miss and a fill of that line is refused.
- R9: A line is `LINE_BYTES` bytes. The low log2(`LINE_BYTES`) address bits are ignored when lines are matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup byte address |
| mc_hit | input | 1 | Main cache hit for the same lookup |
| mc_data | input | LINE_BYTES*8 | Main cache line for the same lookup |
| lk_hit | output | 1 | Merged hit |
| lk_from_bb | output | 1 | Line came from this buffer |
| lk_data | output | LINE_BYTES*8 | Merged line |
| fill_valid | input | 1 | Fill request this cycle |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_data | input | LINE_BYTES*8 | Fill line |
| fill_priv | input | 1 | Requester is the privileged thread |
| fill_conflict | input | 1 | Main cache cannot take the line |
| fill_taken | output | 1 | Fill accepted into the buffer |
| inv_valid | input | 1 | Invalidate request this cycle |
| inv_addr | input | ADDR_W | Invalidate byte address |

## Verification
A vector table runs fills with each combination of the privileged and conflict flags, then looks up each line. This separates an accepted fill from a refused one and a resident line from an absent one. Lookups use both the main-cache-hit and main-cache-miss patterns, so that data priority can be told apart from simple pass-through, and they use nonzero line offsets so that offset masking is exercised. A directed sequence fills every slot, refreshes some slots by hits and in-place refills, and frees one slot by invalidation. Each following eviction then points to exactly one victim, which tells invalid-first allocation apart from true LRU order. Invalidates that collide with a same-cycle lookup or fill check the ordering within the cycle.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
    // Source of the line returned to the pipeline on a lookup
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_MAIN   = 2'd1,
        SRC_BYPASS = 2'd2
    } src_e;
endpackage

// File: rtl/bb_match.sv
`timescale 1ns/1ps
module bb_match #(
    parameter int N     = 16,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]        key_i,
    output logic [N-1:0]            hit_vec_o,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    assign hit_o = |hit_vec_o;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/bb_lru.sv
`timescale 1ns/1ps
module bb_lru #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_i,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] victim_o
);
    // Age 0 = most recent, N-1 = least recent; ages stay a permutation.
    logic [N-1:0][IDX_W-1:0] age_q;
    logic                    free_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx_i)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_o   = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !free_found) begin
                victim_o   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bb_store.sv
`timescale 1ns/1ps
module bb_store #(
    parameter int N      = 16,
    parameter int TAG_W  = 26,
    parameter int LINE_W = 512,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         widx_i,
    input  logic [TAG_W-1:0]         wtag_i,
    input  logic [LINE_W-1:0]        wdata_i,
    input  logic [N-1:0]             clr_vec_i,
    output logic [N-1:0]             valid_o,
    output logic [N-1:0][TAG_W-1:0]  tags_o,
    output logic [N-1:0][LINE_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we_i && (widx_i == IDX_W'(i)))
                    valid_o[i] <= 1'b1;
                else if (clr_vec_i[i])
                    valid_o[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            tags_o[widx_i] <= wtag_i;
            data_o[widx_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/bypass_buf.sv
`timescale 1ns/1ps
module bypass_buf #(
    parameter int ENTRIES    = 16,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [ADDR_W-1:0]       lk_addr,
    input  logic                    mc_hit,
    input  logic [LINE_BYTES*8-1:0] mc_data,
    output logic                    lk_hit,
    output logic                    lk_from_bb,
    output logic [LINE_BYTES*8-1:0] lk_data,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [LINE_BYTES*8-1:0] fill_data,
    input  logic                    fill_priv,
    input  logic                    fill_conflict,
    output logic                    fill_taken,
    input  logic                    inv_valid,
    input  logic [ADDR_W-1:0]       inv_addr
);
    import bb_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int IDX_W  = $clog2(ENTRIES);

    logic [TAG_W-1:0] lk_tag, fill_tag, inv_tag;
    assign lk_tag   = lk_addr[ADDR_W-1:OFF_W];
    assign fill_tag = fill_addr[ADDR_W-1:OFF_W];
    assign inv_tag  = inv_addr[ADDR_W-1:OFF_W];

    logic unused_offsets;
    assign unused_offsets = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], inv_addr[OFF_W-1:0]};

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] data_q;

    logic [ENTRIES-1:0] lk_hit_vec, fill_vec_unused, inv_hit_vec;
    logic               lk_raw, fill_hit, inv_hit_unused;
    logic [IDX_W-1:0]   lk_idx, fill_idx, inv_idx_unused, victim;

    bb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(lk_tag),
        .hit_vec_o(lk_hit_vec), .hit_o(lk_raw), .idx_o(lk_idx)
    );

    bb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_fill_match (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(fill_tag),
        .hit_vec_o(fill_vec_unused), .hit_o(fill_hit), .idx_o(fill_idx)
    );

    bb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_inv_match (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(inv_tag),
        .hit_vec_o(inv_hit_vec), .hit_o(inv_hit_unused), .idx_o(inv_idx_unused)
    );

    // Same-cycle ordering: invalidate beats lookup and fill of its line
    logic lk_killed, fill_killed, bb_hit;
    assign lk_killed   = inv_valid && (inv_tag == lk_tag);
    assign fill_killed = inv_valid && (inv_tag == fill_tag);
    assign bb_hit      = lk_valid && lk_raw && !lk_killed;
    assign fill_taken  = rst_n && fill_valid && fill_priv && fill_conflict && !fill_killed;

    logic [IDX_W-1:0]   widx;
    logic [ENTRIES-1:0] clr_vec;
    assign widx    = fill_hit ? fill_idx : victim;
    assign clr_vec = inv_valid ? inv_hit_vec : '0;

    // Fill recency takes precedence over lookup recency
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    assign touch     = fill_taken || bb_hit;
    assign touch_idx = fill_taken ? widx : lk_idx;

    bb_store #(.N(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(fill_taken), .widx_i(widx), .wtag_i(fill_tag), .wdata_i(fill_data),
        .clr_vec_i(clr_vec),
        .valid_o(valid_q), .tags_o(tag_q), .data_o(data_q)
    );

    bb_lru #(.N(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_q),
        .touch_i(touch), .touch_idx_i(touch_idx), .victim_o(victim)
    );

    // Output merge
    src_e src;
    always_comb begin
        src = SRC_NONE;
        if (bb_hit)                 src = SRC_BYPASS;
        else if (lk_valid && mc_hit) src = SRC_MAIN;
    end

    always_comb begin
        unique case (src)
            SRC_BYPASS: begin
                lk_hit     = 1'b1;
                lk_from_bb = 1'b1;
                lk_data    = data_q[lk_idx];
            end
            SRC_MAIN: begin
                lk_hit     = 1'b1;
                lk_from_bb = 1'b0;
                lk_data    = mc_data;
            end
            default: begin
                lk_hit     = 1'b0;
                lk_from_bb = 1'b0;
                lk_data    = '0;
            end
        endcase
    end
endmodule

// File: rtl/bypass_buf_chk.sv
`timescale 1ns/1ps
module bypass_buf_chk #(
    parameter int N      = 16,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              mc_hit,
    input logic [LINE_W-1:0] mc_data,
    input logic              lk_hit,
    input logic              lk_from_bb,
    input logic [LINE_W-1:0] lk_data,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [LINE_W-1:0] fill_data,
    input logic              fill_priv,
    input logic              fill_conflict,
    input logic              fill_taken,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic [N-1:0]      valid_q,
    input logic [N-1:0]      hit_vec
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    a_r2_take_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        fill_taken |-> (fill_valid && fill_priv && fill_conflict));

    a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_taken) && lk_valid && !inv_valid &&
         lk_addr[ADDR_W-1:OFF_W] == $past(fill_addr[ADDR_W-1:OFF_W]))
        |-> (lk_from_bb && lk_data == $past(fill_data)));

    a_r4_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_from_bb));

    a_r5_bb_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_from_bb |-> lk_hit);

    a_r5_main_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && mc_hit && !lk_from_bb) |-> (lk_hit && lk_data == mc_data));

    a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r8_inv_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && inv_valid && lk_addr[ADDR_W-1:OFF_W] == inv_addr[ADDR_W-1:OFF_W])
        |-> !lk_from_bb);

    a_r8_inv_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_valid) && lk_valid &&
         lk_addr[ADDR_W-1:OFF_W] == $past(inv_addr[ADDR_W-1:OFF_W]))
        |-> !lk_from_bb);
endmodule

bind bypass_buf bypass_buf_chk #(
    .N(ENTRIES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .mc_hit(mc_hit), .mc_data(mc_data), .lk_hit(lk_hit), .lk_from_bb(lk_from_bb),
    .lk_data(lk_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_priv(fill_priv), .fill_conflict(fill_conflict),
    .fill_taken(fill_taken), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .valid_q(valid_q), .hit_vec(lk_hit_vec)
);

// File: tb/bypass_buf_tb.sv
`timescale 1ns/1ps
module bypass_buf_tb_top;
    localparam int ENTRIES    = 16;
    localparam int LINE_BYTES = 64;
    localparam int ADDR_W     = 32;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, mc_hit = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0, fill_addr = '0, inv_addr = '0;
    logic [LINE_W-1:0] mc_data = '0, fill_data = '0, lk_data;
    logic lk_hit, lk_from_bb, fill_taken;
    logic fill_valid = 1'b0, fill_priv = 1'b0, fill_conflict = 1'b0, inv_valid = 1'b0;

    int ntot = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bypass_buf #(.ENTRIES(ENTRIES), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .mc_hit(mc_hit), .mc_data(mc_data),
        .lk_hit(lk_hit), .lk_from_bb(lk_from_bb), .lk_data(lk_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_priv(fill_priv), .fill_conflict(fill_conflict), .fill_taken(fill_taken),
        .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    function automatic logic [LINE_W-1:0] mkline(input int tag, input int seed);
        logic [LINE_W-1:0] d;
        for (int w = 0; w < LINE_W / 32; w++)
            d[w*32 +: 32] = 32'(tag * 65536 + seed * 256 + w);
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] mkaddr(input int tag, input int off);
        return ADDR_W'(tag << OFF_W) | ADDR_W'(off);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 1'b0; mc_hit = 1'b0; fill_valid = 1'b0;
        fill_priv = 1'b0; fill_conflict = 1'b0; inv_valid = 1'b0;
    endtask

    task automatic lookup(input int tag, input int off, input logic mh, input int mseed,
                          output logic hit, output logic fb, output logic [LINE_W-1:0] d);
        @(negedge clk);
        clear_inputs();
        lk_valid = 1'b1; lk_addr = mkaddr(tag, off);
        mc_hit = mh; mc_data = mkline(tag, mseed);
        #1;
        hit = lk_hit; fb = lk_from_bb; d = lk_data;
        @(posedge clk); #1;
        clear_inputs();
    endtask

    task automatic fill(input int tag, input int seed, input logic p, input logic c,
                        output logic taken);
        @(negedge clk);
        clear_inputs();
        fill_valid = 1'b1; fill_addr = mkaddr(tag, 5);
        fill_data = mkline(tag, seed); fill_priv = p; fill_conflict = c;
        #1;
        taken = fill_taken;
        @(posedge clk); #1;
        clear_inputs();
    endtask

    task automatic inval(input int tag);
        @(negedge clk);
        clear_inputs();
        inv_valid = 1'b1; inv_addr = mkaddr(tag, 9);
        @(posedge clk); #1;
        clear_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Expect a pure buffer hit with the given line content
    task automatic expect_bb(input int tag, input int seed, input string req);
        logic h, fb;
        logic [LINE_W-1:0] d;
        lookup(tag, 1, 1'b0, 0, h, fb, d);
        chk(h && fb, req, $sformatf("hit tag %0d", tag), {62'd0, h, fb}, 64'd3);
        chk(d == mkline(tag, seed), req, $sformatf("data tag %0d", tag), d[63:0], mkline(tag, seed) >> 0);
    endtask

    task automatic expect_miss(input int tag, input string req);
        logic h, fb;
        logic [LINE_W-1:0] d;
        lookup(tag, 2, 1'b0, 0, h, fb, d);
        chk(!h && !fb, req, $sformatf("miss tag %0d", tag), {62'd0, h, fb}, 64'd0);
    endtask

    typedef struct packed {
        logic [1:0] op;   // 0 lookup, 1 fill, 2 invalidate
        logic [7:0] tag;
        logic       priv;
        logic       conf;
        logic       exp;  // expected buffer hit (lookup) or fill_taken (fill)
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd5, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'd5, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd5, 1'b0, 1'b0, 1'b1},
        '{2'd1, 8'd6, 1'b0, 1'b1, 1'b0},
        '{2'd0, 8'd6, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'd7, 1'b1, 1'b0, 1'b0},
        '{2'd0, 8'd7, 1'b0, 1'b0, 1'b0},
        '{2'd2, 8'd5, 1'b0, 1'b0, 1'b0},
        '{2'd0, 8'd5, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'd9, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'd9, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            ntot++; nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        logic h, fb, tk;
        logic [LINE_W-1:0] d;

        // R1: fill refused while in reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b1; fill_priv = 1'b1; fill_conflict = 1'b1; fill_addr = mkaddr(3, 0);
        #1;
        chk(fill_taken == 1'b0, "R1", "fill_taken in reset", {63'd0, fill_taken}, 64'd0);
        #1;
        clear_inputs();
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: R2 fill gating, R3/R4 lookups
        for (int k = 0; k < NV; k++) begin
            unique case (VECS[k].op)
                2'd0: begin
                    lookup(int'(VECS[k].tag), 7, 1'b0, 0, h, fb, d);
                    chk(fb == VECS[k].exp && h == VECS[k].exp, "R4",
                        $sformatf("vec %0d lookup hit", k), {62'd0, h, fb}, {62'd0, VECS[k].exp, VECS[k].exp});
                    if (VECS[k].exp)
                        chk(d == mkline(int'(VECS[k].tag), 0), "R3",
                            $sformatf("vec %0d data", k), d[63:0], mkline(int'(VECS[k].tag), 0) >> 0);
                end
                2'd1: begin
                    fill(int'(VECS[k].tag), 0, VECS[k].priv, VECS[k].conf, tk);
                    chk(tk == VECS[k].exp, "R2", $sformatf("vec %0d fill_taken", k),
                        {63'd0, tk}, {63'd0, VECS[k].exp});
                end
                default: inval(int'(VECS[k].tag));
            endcase
        end

        // R1: reset empties the buffer (tag 9 was resident)
        do_reset();
        expect_miss(9, "R1");

        // R5: merge with main cache
        fill(20, 0, 1'b1, 1'b1, tk);
        lookup(20, 3, 1'b1, 7, h, fb, d);
        chk(h && fb && d == mkline(20, 0), "R5", "bypass wins over main", d[63:0], mkline(20, 0) >> 0);
        lookup(21, 3, 1'b1, 7, h, fb, d);
        chk(h && !fb && d == mkline(21, 7), "R5", "main pass-through", d[63:0], mkline(21, 7) >> 0);
        lookup(21, 3, 1'b0, 7, h, fb, d);
        chk(!h && !fb, "R5", "both miss", {62'd0, h, fb}, 64'd0);

        // R9: any offset within the line matches
        lookup(20, LINE_BYTES - 1, 1'b0, 0, h, fb, d);
        chk(h && fb, "R9", "last byte offset hits", {62'd0, h, fb}, 64'd3);

        // R8: invalidate with same-cycle lookup
        @(negedge clk);
        clear_inputs();
        inv_valid = 1'b1; inv_addr = mkaddr(20, 0);
        lk_valid = 1'b1; lk_addr = mkaddr(20, 4);
        #1;
        chk(!lk_hit && !lk_from_bb, "R8", "same-cycle lookup misses",
            {62'd0, lk_hit, lk_from_bb}, 64'd0);
        @(posedge clk); #1;
        clear_inputs();
        expect_miss(20, "R8");

        // R8: invalidate with same-cycle fill of the same line
        @(negedge clk);
        clear_inputs();
        inv_valid = 1'b1; inv_addr = mkaddr(30, 0);
        fill_valid = 1'b1; fill_priv = 1'b1; fill_conflict = 1'b1;
        fill_addr = mkaddr(30, 1); fill_data = mkline(30, 0);
        #1;
        chk(fill_taken == 1'b0, "R8", "same-cycle fill refused", {63'd0, fill_taken}, 64'd0);
        @(posedge clk); #1;
        clear_inputs();
        expect_miss(30, "R8");

        // R6/R7: replacement order
        do_reset();
        for (int t = 100; t < 116; t++) fill(t, 0, 1'b1, 1'b1, tk);
        fill(107, 1, 1'b1, 1'b1, tk);
        chk(tk == 1'b1, "R7", "refill accepted", {63'd0, tk}, 64'd1);
        expect_bb(100, 0, "R7");
        fill(116, 0, 1'b1, 1'b1, tk);
        expect_miss(101, "R6");
        expect_bb(116, 0, "R6");
        expect_bb(107, 1, "R7");
        inval(105);
        expect_miss(105, "R8");
        fill(118, 0, 1'b1, 1'b1, tk);
        expect_bb(102, 0, "R6");
        expect_bb(118, 0, "R6");
        fill(119, 0, 1'b1, 1'b1, tk);
        expect_miss(103, "R6");
        expect_bb(104, 0, "R6");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule